// File: doc/BRIEF.md
# Audio Transmit FIFO DMA Bridge

This block sits between a host (or DMA engine) and the transmit side of an audio serial port. It can run in two modes. In bypass, the default, the block is transparent: the peripheral's transmit request goes straight to the host, and host write data goes straight to the peripheral. In buffered mode, host words are stored in a 64-entry, 32-bit FIFO. Each request from the peripheral is answered with a programmed burst of N words. The burst is held back until at least N words are stored.

In buffered mode the block makes its own host-side request. This is a one-cycle pulse that fires when free space reaches a programmed threshold T. After a pulse, it re-arms only once T more words have been written. The block reports how many words are stored. A sticky flag records any write dropped because the FIFO was full. If N is zero or larger than the depth, the enable is ignored. Dropping the enable empties the FIFO and returns the block to bypass.

Top module: `atx_fifo_bridge`

## Requirements
- R1: After reset the block is in bypass. In bypass, `host_tx_req` equals `per_tx_req`, and `per_wr_valid`/`per_wr_data` equal `host_wr_valid`/`host_wr_data` in the same cycle. The stored count stays 0.
- R2: While `cfg_burst_len` is 0 or greater than 64, asserting `cfg_enable` has no effect. The block stays in bypass and stores nothing.
- R3: In buffered mode, a request sampled on a clock edge when at least N words are stored starts a burst. On that edge and each of the following N-1 edges, `per_wr_valid` goes high with the next stored word, oldest first. It then drops to 0.
- R4: If fewer than N words are stored when a request is sampled, the request is held. The burst starts on the first edge at which the stored count, as of before that edge, is at least N.
- R5: Host writes in buffered mode are accepted whenever the FIFO is not full. A write made while 64 words are stored is discarded and leaves the stored words and the count unchanged.
- R6: On the first cycle after the buffered mode takes effect, `host_tx_req` is high for exactly one cycle.
- R7: After a host pulse, `host_tx_req` stays low until T more words have been written. It then pulses once, provided free space (64 minus count) is at least T. A threshold of 0 acts as 1.
- R8: `status_count` gives the number of stored words after each edge. Each accepted write adds 1 and each delivered burst word subtracts 1.
- R9: `status_ovf` becomes 1 on the edge after a discarded write and stays 1. A `ovf_clear` pulse returns it to 0. If a drop and a clear happen on the same edge, the drop wins.
- R10: Deasserting `cfg_enable` returns the block to bypass on the next edge. On that same edge the count is cleared to 0 and any held request is discarded, so re-enabling does not start a burst left over from before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_enable | input | 1 | Selects buffered mode when the burst length is valid |
| cfg_burst_len | input | 7 | Burst length N, valid range 1 to 64 |
| cfg_host_thresh | input | 7 | Free-space threshold T for the host request |
| ovf_clear | input | 1 | Write-one pulse that clears the overflow flag |
| host_wr_valid | input | 1 | Host write strobe |
| host_wr_data | input | 32 | Host write word |
| per_tx_req | input | 1 | Transmit request from the peripheral |
| host_tx_req | output | 1 | Transmit request toward the host |
| per_wr_valid | output | 1 | Word strobe toward the peripheral |
| per_wr_data | output | 32 | Word toward the peripheral |
| status_count | output | 7 | Stored word count |
| status_ovf | output | 1 | Sticky overflow flag |

## Verification
The bench goes after the corner cases below. Each one names the fault that a wrong design would show.

- **Invalid burst length.** With N set to 0 or to 65, the bench asserts the enable. A design that skipped the length check would start storing words and stop passing data through.
- **Held request.** A request arrives while the FIFO is below N words. The bench then checks that the burst begins exactly one edge after the count reaches N. A design that did not hold the request would never deliver. One that started early would send words that were not yet stored.
- **Full FIFO.** The FIFO is filled to 64 words and then written again. The bench reads all 64 words back in a single burst, which shows whether a dropped write overwrote data, moved the count, or failed to set the flag.
- **Disable with a request held.** The block is disabled while a request is held, then re-enabled and refilled past N. A design that did not flush would emit a stale burst at that point.

// File: rtl/atx_pkg.sv
package atx_pkg;

   // A burst length is usable only when it is nonzero and fits in the store.
   function automatic bit len_ok(input int unsigned len, input int unsigned depth);
      return (len != 0) && (len <= depth);
   endfunction

endpackage

// File: rtl/atx_store.sv
module atx_store #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 64,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [DATA_W-1:0] pop_data,
   output logic [CNT_W-1:0]  count,
   output logic              full
);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr;
   logic              push_en;

   assign full     = (count == CNT_W'(DEPTH));
   assign push_en  = push && !full;
   assign pop_data = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push_en) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_en) wr_ptr <= wr_ptr + PTR_W'(1);
         if (pop)     rd_ptr <= rd_ptr + PTR_W'(1);
         count <= count + CNT_W'(push_en) - CNT_W'(pop);
      end
   end

   // R8: the count never exceeds the depth
   a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));

   // R5: a write into a full store, with no pop, leaves the count alone
   a_r5_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop && !flush) |=> (count == $past(count)));

endmodule

// File: rtl/atx_burst.sv
module atx_burst #(
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             active,
   input  logic             req,
   input  logic [CNT_W-1:0] burst_len,
   input  logic [CNT_W-1:0] count,
   output logic             pop
);

   logic [CNT_W-1:0] left_q;
   logic             pend_q;
   logic             busy, start;

   assign busy  = (left_q != '0);
   assign start = active && !busy && (pend_q || req) && (count >= burst_len);
   assign pop   = busy || start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q <= '0;
         pend_q <= 1'b0;
      end else if (flush) begin
         left_q <= '0;
         pend_q <= 1'b0;
      end else if (start) begin
         left_q <= burst_len - CNT_W'(1);
         pend_q <= 1'b0;
      end else if (busy) begin
         left_q <= left_q - CNT_W'(1);
      end else if (active && req) begin
         pend_q <= 1'b1;
      end
   end

   // R3: a word is only taken from a non-empty store
   a_r3_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> (count != '0));

   // R4: a held request never coexists with a running burst
   a_r4_pend_idle: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !pend_q);

endmodule

// File: rtl/atx_host_req.sv
module atx_host_req #(
   parameter int DEPTH = 64,
   localparam int CNT_W = $clog2(DEPTH) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             active,
   input  logic             push,
   input  logic [CNT_W-1:0] count,
   input  logic [CNT_W-1:0] thresh,
   output logic             pulse
);

   logic [CNT_W-1:0] t_eff, free, wr_since_q;
   logic             rearm_q;

   assign t_eff = (thresh == '0) ? CNT_W'(1) : thresh;
   assign free  = CNT_W'(DEPTH) - count;
   assign pulse = active && (rearm_q || (wr_since_q >= t_eff)) && (free >= t_eff);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rearm_q    <= 1'b1;
         wr_since_q <= '0;
      end else if (flush) begin
         rearm_q    <= 1'b1;
         wr_since_q <= '0;
      end else if (pulse) begin
         rearm_q    <= 1'b0;
         wr_since_q <= CNT_W'(push);
      end else if (push && (wr_since_q != '1)) begin
         wr_since_q <= wr_since_q + CNT_W'(1);
      end
   end

   // R7: with no write in between, a pulse is never repeated
   a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse && !push) |=> !pulse);

endmodule

// File: rtl/atx_fifo_bridge.sv
module atx_fifo_bridge #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 64,
   localparam int CNT_W = $clog2(DEPTH) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_enable,
   input  logic [CNT_W-1:0]  cfg_burst_len,
   input  logic [CNT_W-1:0]  cfg_host_thresh,
   input  logic              ovf_clear,
   input  logic              host_wr_valid,
   input  logic [DATA_W-1:0] host_wr_data,
   input  logic              per_tx_req,
   output logic              host_tx_req,
   output logic              per_wr_valid,
   output logic [DATA_W-1:0] per_wr_data,
   output logic [CNT_W-1:0]  status_count,
   output logic              status_ovf
);

   import atx_pkg::*;

   if (DATA_W < 1) begin : g_bad_width
      $error("atx_fifo_bridge: DATA_W must be positive");
   end
   if ((DEPTH < 2) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_bad_depth
      $error("atx_fifo_bridge: DEPTH must be a power of two, at least 2");
   end

   logic              active_q, active_d, flush;
   logic              pop, full, fifo_pulse, push, drop;
   logic [DATA_W-1:0] pop_data, out_data_q;
   logic              out_valid_q, ovf_q;
   logic [CNT_W-1:0]  count;

   assign active_d = cfg_enable && len_ok(32'(cfg_burst_len), DEPTH);
   assign flush    = !active_d;
   assign push     = active_q && host_wr_valid;
   assign drop     = push && full;

   atx_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .push(push), .push_data(host_wr_data),
      .pop(pop), .pop_data(pop_data),
      .count(count), .full(full)
   );

   atx_burst #(.CNT_W(CNT_W)) u_burst (
      .clk(clk), .rst_n(rst_n), .flush(flush), .active(active_q),
      .req(per_tx_req), .burst_len(cfg_burst_len), .count(count),
      .pop(pop)
   );

   atx_host_req #(.DEPTH(DEPTH)) u_hreq (
      .clk(clk), .rst_n(rst_n), .flush(flush), .active(active_q),
      .push(push && !full), .count(count), .thresh(cfg_host_thresh),
      .pulse(fifo_pulse)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q    <= 1'b0;
         out_valid_q <= 1'b0;
         out_data_q  <= '0;
         ovf_q       <= 1'b0;
      end else begin
         active_q    <= active_d;
         out_valid_q <= pop && !flush;
         if (pop) out_data_q <= pop_data;
         if (drop)           ovf_q <= 1'b1;
         else if (ovf_clear) ovf_q <= 1'b0;
      end
   end

   assign host_tx_req  = active_q ? fifo_pulse  : per_tx_req;
   assign per_wr_valid = active_q ? out_valid_q : host_wr_valid;
   assign per_wr_data  = active_q ? out_data_q  : host_wr_data;
   assign status_count = count;
   assign status_ovf   = ovf_q;

   // R10: outside buffered mode nothing is stored
   a_r10_bypass_empty: assert property (@(posedge clk) disable iff (!rst_n)
      !active_q |-> (status_count == '0));

   // R9: a discarded write raises the sticky flag
   a_r9_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
      drop |=> status_ovf);

endmodule

// File: tb/tb_atx_fifo_bridge.sv
module tb_atx_fifo_bridge;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_enable = 1'b0;
   logic [6:0]  cfg_burst_len = 7'd0;
   logic [6:0]  cfg_host_thresh = 7'd0;
   logic        ovf_clear = 1'b0;
   logic        host_wr_valid = 1'b0;
   logic [31:0] host_wr_data = '0;
   logic        per_tx_req = 1'b0;
   logic        host_tx_req, per_wr_valid, status_ovf;
   logic [31:0] per_wr_data;
   logic [6:0]  status_count;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   atx_fifo_bridge dut (
      .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable),
      .cfg_burst_len(cfg_burst_len), .cfg_host_thresh(cfg_host_thresh),
      .ovf_clear(ovf_clear), .host_wr_valid(host_wr_valid),
      .host_wr_data(host_wr_data), .per_tx_req(per_tx_req),
      .host_tx_req(host_tx_req), .per_wr_valid(per_wr_valid),
      .per_wr_data(per_wr_data), .status_count(status_count),
      .status_ovf(status_ovf)
   );

   // bypass vectors: {per_req, host_valid, host_data, exp_req, exp_valid, exp_data}
   localparam logic [67:0] BYP_VEC [0:3] = '{
      {1'b1, 1'b0, 32'h0000_0000, 1'b1, 1'b0, 32'h0000_0000},
      {1'b0, 1'b1, 32'hDEAD_BEEF, 1'b0, 1'b1, 32'hDEAD_BEEF},
      {1'b1, 1'b1, 32'h8000_0001, 1'b1, 1'b1, 32'h8000_0001},
      {1'b0, 1'b0, 32'h1234_5678, 1'b0, 1'b0, 32'h1234_5678}
   };

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic write_word(input logic [31:0] d);
      host_wr_valid = 1'b1;
      host_wr_data  = d;
      tick();
      host_wr_valid = 1'b0;
   endtask

   task automatic request();
      per_tx_req = 1'b1;
      tick();
      per_tx_req = 1'b0;
   endtask

   task automatic finish_sim();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_sim();
   end

   initial begin
      int bad;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      tick();

      // R1 reset state
      chk(host_tx_req, 0, "R1 reset req");
      chk(status_count, 0, "R1 reset count");
      chk(status_ovf, 0, "R9 reset ovf");

      // R1 bypass pass-through table
      foreach (BYP_VEC[i]) begin
         per_tx_req    = BYP_VEC[i][67];
         host_wr_valid = BYP_VEC[i][66];
         host_wr_data  = BYP_VEC[i][65:34];
         #1;
         chk(host_tx_req,  BYP_VEC[i][33], "R1 bypass req");
         chk(per_wr_valid, BYP_VEC[i][32], "R1 bypass valid");
         chk(per_wr_data,  BYP_VEC[i][31:0], "R1 bypass data");
         tick();
         chk(status_count, 0, "R1 bypass count");
      end
      per_tx_req = 1'b0;
      host_wr_valid = 1'b0;

      // R2 invalid burst lengths 0 and 65
      cfg_host_thresh = 7'd8;
      cfg_enable = 1'b1;
      cfg_burst_len = 7'd0;
      tick(); tick();
      write_word(32'h5555_0000);
      chk(status_count, 0, "R2 len0 count");
      per_tx_req = 1'b1; #1;
      chk(host_tx_req, 1, "R2 len0 req passthrough");
      per_tx_req = 1'b0;
      cfg_burst_len = 7'd65;
      tick(); tick();
      host_wr_valid = 1'b1; host_wr_data = 32'hCAFE_0065; #1;
      chk(per_wr_valid, 1, "R2 len65 valid passthrough");
      chk(per_wr_data, 32'hCAFE_0065, "R2 len65 data passthrough");
      tick();
      host_wr_valid = 1'b0;
      chk(status_count, 0, "R2 len65 count");

      // R6 enable with N=4, T=8
      cfg_burst_len = 7'd4;
      tick();
      chk(host_tx_req, 1, "R6 pulse after enable");
      tick();
      chk(host_tx_req, 0, "R6 pulse single cycle");

      // R7 rearm after T writes
      bad = 0;
      for (int k = 0; k < 7; k++) begin
         write_word(32'hA000_0000 + k);
         if (host_tx_req !== 1'b0) bad++;
      end
      chk(bad, 0, "R7 no pulse before T writes");
      write_word(32'hA000_0007);
      chk(host_tx_req, 1, "R7 pulse after T writes");
      chk(status_count, 8, "R8 count after 8 writes");
      tick();
      chk(host_tx_req, 0, "R7 pulse single cycle");

      // R3 burst of 4 with enough data
      request();
      chk(per_wr_valid, 1, "R3 burst starts");
      chk(per_wr_data, 32'hA000_0000, "R3 first word");
      bad = 0;
      for (int k = 1; k < 4; k++) begin
         tick();
         if (per_wr_valid !== 1'b1 || per_wr_data !== 32'hA000_0000 + k) bad++;
      end
      chk(bad, 0, "R3 burst words in order");
      tick();
      chk(per_wr_valid, 0, "R3 burst ends after N");
      chk(status_count, 4, "R8 count after burst");

      // R4 held request, N=6 with 4 stored
      cfg_burst_len = 7'd6;
      request();
      chk(per_wr_valid, 0, "R4 held when short");
      write_word(32'hA000_0008);
      chk(per_wr_valid, 0, "R4 held at five");
      write_word(32'hA000_0009);
      chk(per_wr_valid, 0, "R4 not early");
      tick();
      chk(per_wr_valid, 1, "R4 starts after reaching N");
      chk(per_wr_data, 32'hA000_0004, "R4 first word");
      bad = 0;
      for (int k = 5; k < 10; k++) begin
         tick();
         if (per_wr_valid !== 1'b1 || per_wr_data !== 32'hA000_0000 + k) bad++;
      end
      chk(bad, 0, "R4 burst words");
      tick();
      chk(per_wr_valid, 0, "R4 burst ends");
      chk(status_count, 0, "R8 empty after burst");

      // R5 fill and overflow
      for (int k = 0; k < 64; k++) write_word(32'hB000_0000 + k);
      chk(status_count, 64, "R8 full count");
      chk(status_ovf, 0, "R9 no ovf before drop");
      for (int k = 0; k < 3; k++) write_word(32'hDEAD_0000 + k);
      chk(status_count, 64, "R5 count unchanged on drop");
      chk(status_ovf, 1, "R9 ovf set");
      cfg_burst_len = 7'd64;
      request();
      bad = 0;
      for (int k = 0; k < 64; k++) begin
         if (per_wr_valid !== 1'b1 || per_wr_data !== 32'hB000_0000 + k) bad++;
         tick();
      end
      chk(bad, 0, "R5 stored words intact");
      chk(per_wr_valid, 0, "R3 full burst ends");
      chk(status_ovf, 1, "R9 ovf sticky");
      ovf_clear = 1'b1;
      tick();
      ovf_clear = 1'b0;
      chk(status_ovf, 0, "R9 ovf cleared");

      // R10 disable flush with held request
      cfg_burst_len = 7'd10;
      for (int k = 0; k < 5; k++) write_word(32'hC000_0000 + k);
      request();
      chk(status_count, 5, "R8 count before disable");
      cfg_enable = 1'b0;
      tick();
      chk(status_count, 0, "R10 flushed");
      per_tx_req = 1'b1;
      host_wr_valid = 1'b1; host_wr_data = 32'h7777_0001; #1;
      chk(host_tx_req, 1, "R10 bypass req");
      chk(per_wr_data, 32'h7777_0001, "R10 bypass data");
      per_tx_req = 1'b0;
      host_wr_valid = 1'b0;
      cfg_enable = 1'b1;
      tick();
      chk(host_tx_req, 1, "R6 pulse after re-enable");
      bad = 0;
      for (int k = 0; k < 10; k++) begin
         write_word(32'hE000_0000 + k);
         if (per_wr_valid !== 1'b0) bad++;
      end
      tick();
      if (per_wr_valid !== 1'b0) bad++;
      chk(bad, 0, "R10 no stale burst");
      chk(status_count, 10, "R10 count after refill");

      finish_sim();
   end

endmodule